// File: doc/BRIEF.md
# Programmable Display Sync Pattern Generator

This block produces the four timing outputs of a display pipe: horizontal sync, vertical sync, data enable and an end-of-frame strobe. A free-running pixel and line counter drives it. The counter wraps at the line and frame sizes given on configuration inputs. No edge comes from fixed porch counters. Five pattern units each hold a level that is set and cleared by two masked position comparators. A mixer then forms every output from up to three unit levels through an 8-entry truth table.

Software loads positions, masks, selectors, tables and a bypass bit through a one-cycle write port. Writes land in shadow storage. The shadow is copied into the working set at the start of each frame, so a new mode never tears a frame. While bypass is set, all outputs stay low. Clearing bypass lets the generated timing through, normally once a dummy frame has passed.

Top module: `sync_pattern_gen`

## Requirements
- R1: After reset the pixel counter counts 0, 1, … up to `htotal`−1 and then returns to 0, which advances the line counter. The line counter returns to 0 after line `vtotal`−1.
- R2: A position word carries the pixel field in bits 30:16 and the line field in bits 14:0. A set bit in a mask word removes that counter bit from the comparison.
- R3: A pattern unit's level rises at the position where the unmasked counter bits equal its on-position, falls where they equal its off-position, and holds otherwise. If both match, the on-position wins.
- R4: The byte map is as follows. Unit n occupies 0x60+16·n, holding on-position, on-mask, off-position and off-mask at +0, +4, +8 and +12. Lane n has its selector at 0x120+8·n and its table at 0x124+8·n. Bit 3 of 0x10 is bypass. Writes to any other address, or to one that is not a multiple of 4, are ignored.
- R5: Selector bits 2:0, 5:3 and 8:6 choose the index bits 0, 1 and 2. Code k+2 selects unit k. Codes 0 and 1, and codes that name no existing unit, give 0. The lane value is the table bit at that index.
- R6: Lanes 0 to 3 drive `hsync`, `vsync`, `de` and `frame_strobe`. Each output is registered: after a clock edge it shows the value computed for the counter position held before that edge.
- R7: Written values take effect only from the clock edge at which the counter leaves position (`htotal`−1, `vtotal`−1).
- R8: While the working bypass bit is 1, all four outputs are 0.
- R9: Reset clears every register to 0, except bypass, which resets to 1. All outputs are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htotal | input | 15 | Pixels per line, blanking included |
| vtotal | input | 15 | Lines per frame, blanking included |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register byte address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Mixer lane 0 |
| vsync | output | 1 | Mixer lane 1 |
| de | output | 1 | Mixer lane 2 |
| frame_strobe | output | 1 | Mixer lane 3 |

## Verification
The first input pattern is a conventional mode: an inverted single-unit hsync, a vsync that changes at an exact pixel-and-line point, a data enable formed as the AND of a line-repeating window and a frame window, and a strobe on one line. This pattern separates the line-only, frame-only and exact masks, and shows whether the comparisons are cycle-accurate. A second pattern uses partial pixel masks, which shows whether masking works bit by bit rather than field by field. A third pattern uses selectors with constant-zero codes, codes for units that do not exist, and a three-input XOR table, which exposes faults in index ordering and code decoding. Further runs change the totals in mid-stream, write to unmapped and misaligned addresses, and rewrite registers in the middle of a frame. These runs separate counter wrap faults, decode faults and faults where a write takes effect too early.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int POS_W  = 15;
    localparam int WORD_W = 32;
    localparam int X_LSB  = 16;
    localparam int CODE_W = 3;
    localparam int SLOTS  = 3;
    localparam int TBL_W  = 1 << SLOTS;
    localparam int SEL_W  = CODE_W * SLOTS;
    localparam int CODE_BIAS = 2;

    typedef struct packed {
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
    } pos_t;

    typedef struct packed {
        pos_t on_pos;
        pos_t on_mask;
        pos_t off_pos;
        pos_t off_mask;
    } unit_cfg_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [TBL_W-1:0] tbl;
    } lane_cfg_t;

    function automatic pos_t word_to_pos(input logic [WORD_W-1:0] w);
        pos_t p;
        p.x = w[X_LSB +: POS_W];
        p.y = w[0 +: POS_W];
        return p;
    endfunction
endpackage

// File: rtl/spg_counter.sv
module spg_counter
    import spg_pkg::*;
#(
    parameter int W = POS_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] htotal,
    input  logic [W-1:0] vtotal,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         line_end,
    output logic         frame_end
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
    } cnt_t;

    cnt_t st_q, st_d;
    logic last_line;

    always_comb begin
        st_d      = st_q;
        line_end  = ((W+1)'(st_q.x) + (W+1)'(1)) >= (W+1)'(htotal);
        last_line = ((W+1)'(st_q.y) + (W+1)'(1)) >= (W+1)'(vtotal);
        frame_end = line_end && last_line;
        if (line_end) begin
            st_d.x = '0;
            st_d.y = last_line ? '0 : st_q.y + W'(1);
        end else begin
            st_d.x = st_q.x + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x = st_q.x;
    assign y = st_q.y;

    AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (st_q.x == '0)); // R1
    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> (st_q.x == $past(st_q.x) + W'(1))); // R1
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (st_q.y == '0)); // R1
endmodule

// File: rtl/spg_pattern_unit.sv
module spg_pattern_unit
    import spg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pos_t      pos,
    input  unit_cfg_t cfg,
    output logic      level
);
    typedef struct packed {
        logic lvl;
    } unit_state_t;

    unit_state_t st_q, st_d;
    logic hit_on, hit_off;

    always_comb begin
        hit_on  = ((pos ^ cfg.on_pos)  & ~cfg.on_mask)  == '0;
        hit_off = ((pos ^ cfg.off_pos) & ~cfg.off_mask) == '0;
        st_d    = st_q;
        if (hit_on)       st_d.lvl = 1'b1;
        else if (hit_off) st_d.lvl = 1'b0;
        level = st_d.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_on |=> st_q.lvl); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_on && !hit_off) |=> $stable(st_q.lvl)); // R3
endmodule

// File: rtl/spg_mix_lane.sv
module spg_mix_lane
    import spg_pkg::*;
#(
    parameter int UNITS = 5
) (
    input  logic [UNITS-1:0] levels,
    input  lane_cfg_t        cfg,
    output logic             mix
);
    logic [SLOTS-1:0] idx;

    function automatic logic pick(input logic [CODE_W-1:0] code,
                                  input logic [UNITS-1:0] lv);
        logic r;
        r = 1'b0;
        for (int k = 0; k < UNITS; k++) begin
            if (int'(code) == k + CODE_BIAS) r = lv[k];
        end
        return r;
    endfunction

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            idx[s] = pick(cfg.sel[s*CODE_W +: CODE_W], levels);
        end
        mix = cfg.tbl[idx];
    end
endmodule

// File: rtl/sync_pattern_gen.sv
module sync_pattern_gen
    import spg_pkg::*;
#(
    parameter int NUM_UNITS   = 5,
    parameter int ADDR_W      = 9,
    parameter int CTRL_OFS    = 'h10,
    parameter int BYPASS_BIT  = 3,
    parameter int UNIT_BASE   = 'h60,
    parameter int UNIT_STRIDE = 16,
    parameter int LANE_BASE   = 'h120,
    parameter int LANE_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  htotal,
    input  logic [POS_W-1:0]  vtotal,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              frame_strobe
);
    localparam int NUM_LANES = 4;
    localparam int UNIT_REGS = 4;
    localparam int REG_BYTES = 4;
    localparam int TBL_OFS   = 4;

    typedef struct packed {
        logic                              bypass;
        unit_cfg_t [NUM_UNITS-1:0]         unit;
        lane_cfg_t [NUM_LANES-1:0]         lane;
    } cfg_t;

    typedef struct packed {
        cfg_t                  shadow;
        cfg_t                  active;
        logic [NUM_LANES-1:0]  out;
    } top_state_t;

    top_state_t st_q, st_d;

    logic [POS_W-1:0]      cnt_x, cnt_y;
    logic                  line_end, frame_end;
    pos_t                  cur_pos;
    logic [NUM_UNITS-1:0]  unit_lvl;
    logic [NUM_LANES-1:0]  mix_vec;

    spg_counter #(.W(POS_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .htotal    (htotal),
        .vtotal    (vtotal),
        .x         (cnt_x),
        .y         (cnt_y),
        .line_end  (line_end),
        .frame_end (frame_end)
    );

    assign cur_pos.x = cnt_x;
    assign cur_pos.y = cnt_y;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        spg_pattern_unit u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .pos   (cur_pos),
            .cfg   (st_q.active.unit[u]),
            .level (unit_lvl[u])
        );
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        spg_mix_lane #(.UNITS(NUM_UNITS)) u_lane (
            .levels (unit_lvl),
            .cfg    (st_q.active.lane[l]),
            .mix    (mix_vec[l])
        );
    end

    always_comb begin
        st_d = st_q;
        if (frame_end) st_d.active = st_q.shadow;

        if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_OFS)) begin
                st_d.shadow.bypass = wr_data[BYPASS_BIT];
            end
            for (int u = 0; u < NUM_UNITS; u++) begin
                for (int f = 0; f < UNIT_REGS; f++) begin
                    if (wr_addr == ADDR_W'(UNIT_BASE + u*UNIT_STRIDE + f*REG_BYTES)) begin
                        case (f)
                            0:       st_d.shadow.unit[u].on_pos   = word_to_pos(wr_data);
                            1:       st_d.shadow.unit[u].on_mask  = word_to_pos(wr_data);
                            2:       st_d.shadow.unit[u].off_pos  = word_to_pos(wr_data);
                            default: st_d.shadow.unit[u].off_mask = word_to_pos(wr_data);
                        endcase
                    end
                end
            end
            for (int l = 0; l < NUM_LANES; l++) begin
                if (wr_addr == ADDR_W'(LANE_BASE + l*LANE_STRIDE)) begin
                    st_d.shadow.lane[l].sel = wr_data[SEL_W-1:0];
                end
                if (wr_addr == ADDR_W'(LANE_BASE + l*LANE_STRIDE + TBL_OFS)) begin
                    st_d.shadow.lane[l].tbl = wr_data[TBL_W-1:0];
                end
            end
        end

        st_d.out = st_q.active.bypass ? '0 : mix_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.shadow.bypass <= 1'b1;
            st_q.active.bypass <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync        = st_q.out[0];
    assign vsync        = st_q.out[1];
    assign de           = st_q.out[2];
    assign frame_strobe = st_q.out[3];

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active.bypass |=> (st_q.out == '0)); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_q.active)); // R7
    AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.shadow)); // R4
endmodule

// File: tb/sync_pattern_gen_bench.sv
module sync_pattern_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] htotal = 15'd20;
    logic [14:0] vtotal = 15'd12;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, frame_strobe;

    int    total = 0;
    int    bad = 0;
    string phase = "R9";
    logic [3:0] expq[$];

    always #10 clk = ~clk;

    sync_pattern_gen u_sync_pattern_gen (
        .clk(clk), .rst_n(rst_n), .htotal(htotal), .vtotal(vtotal),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .de(de), .frame_strobe(frame_strobe)
    );

    // reference model built from the requirements
    logic [31:0] sh_u[5][4], ac_u[5][4];
    logic [8:0]  sh_sel[4], ac_sel[4];
    logic [7:0]  sh_tbl[4], ac_tbl[4];
    logic        sh_byp, ac_byp;
    logic        m_lvl[5];
    logic [14:0] m_x, m_y;

    function automatic logic hit(input logic [31:0] p, input logic [31:0] c, input logic [31:0] m);
        return (((p ^ c) & ~m) & 32'h7FFF_7FFF) == 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < 5; u++) begin
                m_lvl[u] = 1'b0;
                for (int f = 0; f < 4; f++) begin sh_u[u][f] = '0; ac_u[u][f] = '0; end
            end
            for (int l = 0; l < 4; l++) begin
                sh_sel[l] = '0; ac_sel[l] = '0; sh_tbl[l] = '0; ac_tbl[l] = '0;
            end
            sh_byp = 1'b1; ac_byp = 1'b1; m_x = '0; m_y = '0;
        end else begin
            logic [31:0] p;
            logic [3:0]  e;
            logic        le, ll;
            p = {1'b0, m_x, 1'b0, m_y};
            for (int u = 0; u < 5; u++) begin
                if (hit(p, ac_u[u][0], ac_u[u][1]))      m_lvl[u] = 1'b1;
                else if (hit(p, ac_u[u][2], ac_u[u][3])) m_lvl[u] = 1'b0;
            end
            for (int l = 0; l < 4; l++) begin
                logic [2:0] idx;
                for (int s = 0; s < 3; s++) begin
                    int c;
                    c = int'(ac_sel[l][s*3 +: 3]);
                    idx[s] = (c >= 2 && c - 2 < 5) ? m_lvl[c-2] : 1'b0;
                end
                e[l] = ac_tbl[l][idx];
            end
            if (ac_byp) e = 4'b0;
            expq.push_back(e);
            le = (16'(m_x) + 16'd1) >= 16'(htotal);
            ll = (16'(m_y) + 16'd1) >= 16'(vtotal);
            if (le && ll) begin
                ac_u = sh_u; ac_sel = sh_sel; ac_tbl = sh_tbl; ac_byp = sh_byp;
            end
            if (le) begin m_x = '0; m_y = ll ? '0 : m_y + 15'd1; end
            else m_x = m_x + 15'd1;
            if (wr_en) begin
                if (wr_addr == 9'h010) sh_byp = wr_data[3];
                for (int u = 0; u < 5; u++)
                    for (int f = 0; f < 4; f++)
                        if (int'(wr_addr) == 'h60 + 16*u + 4*f) sh_u[u][f] = wr_data;
                for (int l = 0; l < 4; l++) begin
                    if (int'(wr_addr) == 'h120 + 8*l) sh_sel[l] = wr_data[8:0];
                    if (int'(wr_addr) == 'h124 + 8*l) sh_tbl[l] = wr_data[7:0];
                end
            end
        end
    end

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (rst_n && expq.size() > 0) begin
            logic [3:0] e, a;
            e = expq.pop_front();
            a = {frame_strobe, de, vsync, hsync};
            total++;
            if (a !== e) begin
                bad++;
                $display("FAIL %s outputs {strobe,de,vsync,hsync} got %b exp %b at %0t", phase, a, e, $time);
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] xy(input int x, input int y);
        return {1'b0, 15'(x), 1'b0, 15'(y)};
    endfunction

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        // R9: outputs low while reset is held
        repeat (4) begin
            @(negedge clk);
            total++;
            if ({frame_strobe, de, vsync, hsync} !== 4'b0) begin
                bad++;
                $display("FAIL R9 reset outputs got %b exp 0000", {frame_strobe, de, vsync, hsync});
            end
        end
        rst_n = 1'b1;
        phase = "R8";
        run(300);

        // R4: standard mode, plus writes that must be ignored
        phase = "R4";
        wr(9'h060, xy(12, 0)); wr(9'h064, 32'h0000_FFFF);
        wr(9'h068, xy(15, 0)); wr(9'h06C, 32'h0000_FFFF);
        wr(9'h070, xy(12, 7)); wr(9'h074, 32'h0);
        wr(9'h078, xy(12, 9)); wr(9'h07C, 32'h0);
        wr(9'h080, xy(0, 0));  wr(9'h084, 32'h0000_FFFF);
        wr(9'h088, xy(10, 0)); wr(9'h08C, 32'h0000_FFFF);
        wr(9'h090, xy(0, 0));  wr(9'h094, 32'h7FFF_0000);
        wr(9'h098, xy(0, 6));  wr(9'h09C, 32'h7FFF_0000);
        wr(9'h0A0, xy(0, 7));  wr(9'h0A4, 32'h0);
        wr(9'h0A8, xy(5, 7));  wr(9'h0AC, 32'h0);
        wr(9'h120, 32'h2);  wr(9'h124, 32'h1);
        wr(9'h128, 32'h3);  wr(9'h12C, 32'h1);
        wr(9'h130, 32'h2C); wr(9'h134, 32'h8);
        wr(9'h138, 32'h6);  wr(9'h13C, 32'h2);
        wr(9'h1F0, 32'hFFFF_FFFF);
        wr(9'h004, 32'hFFFF_FFFF);
        wr(9'h061, 32'hFFFF_FFFF);
        wr(9'h010, 32'h0);
        phase = "R7";
        run(200);
        phase = "R3";
        run(480);
        phase = "R6";
        run(240);

        // R2: partial pixel masks on the strobe unit
        phase = "R2";
        wr(9'h0A4, 32'h0003_0000);
        wr(9'h0AC, 32'h0001_0000);
        run(500);

        // R5: constant and absent-unit codes, three-input table
        phase = "R5";
        wr(9'h138, 32'h1CA); wr(9'h13C, 32'hFE);
        wr(9'h130, 32'h19A); wr(9'h134, 32'h96);
        run(500);

        // R1: totals changed in mid-stream
        phase = "R1";
        @(negedge clk);
        htotal = 15'd17; vtotal = 15'd9;
        run(400);

        // R8: bypass re-engaged
        phase = "R8";
        wr(9'h010, 32'h8);
        run(400);
        finish_up();
    end
endmodule